// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Protection

This block caches virtual-to-physical page translations for 4 KB pages and sits between a load/store/fetch pipeline and a hardware page table walker. A request carries a virtual address and an access kind. If the page number matches a cached entry, the physical address comes back combinationally in the same cycle as the request. If it does not match, the block raises a walk request, stalls new requests, writes the walker's answer into a victim entry and then repeats the lookup to produce the response.

Each cached entry holds a write-permit bit and an execute-permit bit. Every response checks them against the access kind. A write to a page without write permission, or a fetch from a page that is not executable, produces a fault response instead of an address. If the walker reports that the page is absent, the fault goes out at once and the entry is not kept. A one-cycle flush input drops every entry, as a context switch does when it reloads the page table root.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, walk_req_valid is 0 and rsp_valid is 0. No entry is valid.
- R2: On a hit, rsp_valid rises combinationally in the cycle the request is presented, no walk is issued, and rsp_pa = {cached frame, req_va[11:0]}.
- R3: On a miss, walk_req_valid is raised with walk_req_vpn = req_va[VA_W-1:12] and held until walk_rsp_valid, with req_ready low the whole time. A present answer is installed and the response follows in the next cycle (two cycles after the request).
- R4: Access kind encoding is 0 = read, 1 = write, 2 = execute, 3 = treated as read. A write to an entry with write permit 0 returns rsp_fault = 1 and code 1, with rsp_fault_va equal to the request address.
- R5: An execute access to an entry with execute permit 0 returns rsp_fault = 1 and code 2, with rsp_fault_va equal to the request address.
- R6: A read of any cached page, a write to a writable page and a fetch from an executable page complete with rsp_fault = 0 and code 3.
- R7: A walk answer with walk_rsp_present = 0 yields rsp_fault = 1 with code 0 in the same cycle and is not installed, so a repeated access walks again.
- R8: A one-cycle pulse on flush invalidates every entry, so the next access to any previously cached page walks again.
- R9: Installs go to the lowest-numbered invalid entry. When every entry is valid, the victim is a round-robin pointer that starts at entry 0 after reset and advances by one on each install into a full buffer. Flush does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Virtual address |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_pa | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fault_code | output | 2 | 0 absent, 1 write, 2 execute, 3 none |
| rsp_fault_va | output | VA_W | Virtual address of the response |
| walk_req_valid | output | 1 | Walk request to the walker |
| walk_req_vpn | output | VA_W-12 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_present | input | 1 | Page is mapped |
| walk_rsp_pfn | input | PA_W-12 | Physical frame number |
| walk_rsp_writable | input | 1 | Write permit |
| walk_rsp_exec | input | 1 | Execute permit |

## Verification
The bench counts walks per access, which separates a true hit from a silent refill. A design that installed absent pages would stop walking on the second access to an unmapped page. A design that ignored flush would keep hitting. The permission tests make the same page fault on a miss-then-replay and again on a plain hit, so a check placed on only one path is caught. The replacement test fills the whole buffer, then evicts three entries in a row and checks which pages still hit. This exposes a pointer that starts at the wrong entry, fails to advance, or overwrites a free slot's neighbour.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_ABSENT = 2'd0,
      FLT_WPROT  = 2'd1,
      FLT_XPROT  = 2'd2,
      FLT_NONE   = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WALK   = 2'd1,
      ST_REPLAY = 2'd2
   } xl_state_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int DEPTH = 64,
   parameter int VPN_W = 36,
   parameter int PFN_W = 40,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic              wr_w,
   input  logic              wr_x,
   output logic              hit,
   output logic [DEPTH-1:0]  hit_vec,
   output logic [PFN_W-1:0]  hit_pfn,
   output logic              hit_w,
   output logic              hit_x,
   output logic [DEPTH-1:0]  valid_vec
);

   logic [DEPTH-1:0][PFN_W-1:0] pfn_m;
   logic [DEPTH-1:0]            w_m;
   logic [DEPTH-1:0]            x_m;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic             v_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PFN_W-1:0] pfn_q;
      logic             w_q;
      logic             x_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            v_q <= 1'b0;
         end else if (sel) begin
            v_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            vpn_q <= wr_vpn;
            pfn_q <= wr_pfn;
            w_q   <= wr_w;
            x_q   <= wr_x;
         end
      end

      assign valid_vec[i] = v_q;
      assign hit_vec[i]   = v_q && (vpn_q == lk_vpn);
      assign pfn_m[i]     = {PFN_W{hit_vec[i]}} & pfn_q;
      assign w_m[i]       = hit_vec[i] & w_q;
      assign x_m[i]       = hit_vec[i] & x_q;
   end

   always_comb begin
      hit_pfn = '0;
      for (int k = 0; k < DEPTH; k++) begin
         hit_pfn = hit_pfn | pfn_m[k];
      end
   end

   assign hit   = |hit_vec;
   assign hit_w = |w_m;
   assign hit_x = |x_m;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEPTH-1:0]  valid_vec,
   input  logic              install,
   output logic [IDX_W-1:0]  victim_idx
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_nxt;
   logic [IDX_W-1:0] free_idx;
   logic             free_found;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end

   if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_wrap
      assign rr_nxt = (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (install && !free_found) begin
         rr_q <= rr_nxt;
      end
   end

   assign victim_idx = free_found ? free_idx : rr_q;

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
(
   input  logic [1:0] acc,
   input  logic       can_w,
   input  logic       can_x,
   output logic       fault,
   output logic [1:0] code
);

   always_comb begin
      fault = 1'b0;
      code  = FLT_NONE;
      unique case (acc_e'(acc))
         ACC_WRITE: if (!can_w) begin
            fault = 1'b1;
            code  = FLT_WPROT;
         end
         ACC_EXEC: if (!can_x) begin
            fault = 1'b1;
            code  = FLT_XPROT;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int PA_W   = 52,
   parameter int PAGE_W = 12,
   parameter int DEPTH  = 64,
   localparam int VPN_W = VA_W - PAGE_W,
   localparam int PFN_W = PA_W - PAGE_W,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic [1:0]        req_type,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_fault,
   output logic [1:0]        rsp_fault_code,
   output logic [VA_W-1:0]   rsp_fault_va,
   output logic              walk_req_valid,
   output logic [VPN_W-1:0]  walk_req_vpn,
   input  logic              walk_rsp_valid,
   input  logic              walk_rsp_present,
   input  logic [PFN_W-1:0]  walk_rsp_pfn,
   input  logic              walk_rsp_writable,
   input  logic              walk_rsp_exec
);

   if (DEPTH < 64 || DEPTH > 128) begin : g_bad_depth
      $error("tlb_xlate: DEPTH must lie in 64..128");
   end
   if (PAGE_W < 1 || PAGE_W >= VA_W || PAGE_W >= PA_W) begin : g_bad_page
      $error("tlb_xlate: PAGE_W must be narrower than both address widths");
   end

   xl_state_e          st_q;
   logic [VA_W-1:0]    pend_va_q;
   logic [1:0]         pend_acc_q;

   logic [VA_W-1:0]    cur_va;
   logic [1:0]         cur_acc;
   logic               accept;
   logic               install;
   logic               absent;
   logic               hit_rsp;

   logic               hit;
   logic [DEPTH-1:0]   hit_vec;
   logic [PFN_W-1:0]   hit_pfn;
   logic               hit_w;
   logic               hit_x;
   logic [DEPTH-1:0]   valid_vec;
   logic [IDX_W-1:0]   victim_idx;
   logic               perm_fault;
   logic [1:0]         perm_code;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign cur_va    = (st_q == ST_IDLE) ? req_va   : pend_va_q;
   assign cur_acc   = (st_q == ST_IDLE) ? req_type : pend_acc_q;
   assign install   = (st_q == ST_WALK) && walk_rsp_valid && walk_rsp_present;
   assign absent    = (st_q == ST_WALK) && walk_rsp_valid && !walk_rsp_present;
   assign hit_rsp   = hit && (accept || (st_q == ST_REPLAY));

   tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .lk_vpn    (cur_va[VA_W-1:PAGE_W]),
      .wr_en     (install),
      .wr_idx    (victim_idx),
      .wr_vpn    (pend_va_q[VA_W-1:PAGE_W]),
      .wr_pfn    (walk_rsp_pfn),
      .wr_w      (walk_rsp_writable),
      .wr_x      (walk_rsp_exec),
      .hit       (hit),
      .hit_vec   (hit_vec),
      .hit_pfn   (hit_pfn),
      .hit_w     (hit_w),
      .hit_x     (hit_x),
      .valid_vec (valid_vec)
   );

   tlb_victim #(.DEPTH(DEPTH)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_vec),
      .install    (install && !flush),
      .victim_idx (victim_idx)
   );

   tlb_perm u_perm (
      .acc   (cur_acc),
      .can_w (hit_w),
      .can_x (hit_x),
      .fault (perm_fault),
      .code  (perm_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pend_va_q  <= '0;
         pend_acc_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept && !hit) begin
               st_q       <= ST_WALK;
               pend_va_q  <= req_va;
               pend_acc_q <= req_type;
            end
            ST_WALK: if (walk_rsp_valid) begin
               st_q <= walk_rsp_present ? ST_REPLAY : ST_IDLE;
            end
            ST_REPLAY: st_q <= hit ? ST_IDLE : ST_WALK;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign walk_req_valid = (st_q == ST_WALK);
   assign walk_req_vpn   = pend_va_q[VA_W-1:PAGE_W];

   assign rsp_valid      = hit_rsp || absent;
   assign rsp_fault      = absent || (hit_rsp && perm_fault);
   assign rsp_fault_code = absent ? FLT_ABSENT : perm_code;
   assign rsp_fault_va   = cur_va;
   assign rsp_pa         = rsp_fault ? '0 : {hit_pfn, cur_va[PAGE_W-1:0]};

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int DEPTH = 64,
   parameter int VPN_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              req_valid,
   input logic              req_ready,
   input logic              walk_req_valid,
   input logic [VPN_W-1:0]  walk_req_vpn,
   input logic              walk_rsp_valid,
   input logic              walk_rsp_present,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [1:0]        rsp_fault_code,
   input logic [DEPTH-1:0]  valid_vec,
   input logic [DEPTH-1:0]  hit_vec
);

   // R3: no new request accepted while a walk is outstanding
   a_r3_stall_walk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> !req_ready);

   // R3: walk address held steady until answered
   a_r3_vpn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && $past(walk_req_valid)) |-> $stable(walk_req_vpn));

   // R3: a walk starts only after an accepted request or a replay
   a_r3_walk_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(walk_req_valid) |-> ($past(req_valid && req_ready) || !$past(req_ready)));

   // R2: at most one entry matches
   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R6: a clean response carries the no-fault code
   a_r6_code_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_fault_code == 2'd3));

   // R7: an absent page is never installed
   a_r7_no_install: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req_valid && walk_rsp_valid && !walk_rsp_present && !flush)
      |=> ($countones(valid_vec) == $countones($past(valid_vec))));

   // R8: flush empties the buffer
   a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));

   // R9: entries are lost only through flush
   a_r9_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flush) |-> ($countones(valid_vec) >= $countones($past(valid_vec))));

endmodule

bind tlb_xlate tlb_xlate_chk #(.DEPTH(DEPTH), .VPN_W(VPN_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .flush            (flush),
   .req_valid        (req_valid),
   .req_ready        (req_ready),
   .walk_req_valid   (walk_req_valid),
   .walk_req_vpn     (walk_req_vpn),
   .walk_rsp_valid   (walk_rsp_valid),
   .walk_rsp_present (walk_rsp_present),
   .rsp_valid        (rsp_valid),
   .rsp_fault        (rsp_fault),
   .rsp_fault_code   (rsp_fault_code),
   .valid_vec        (valid_vec),
   .hit_vec          (hit_vec)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

   localparam int VA_W  = 48;
   localparam int PA_W  = 52;
   localparam int DEPTH = 64;
   localparam int VPN_W = 36;
   localparam int PFN_W = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [VA_W-1:0]   req_va = '0;
   logic [1:0]        req_type = '0;
   logic              rsp_valid;
   logic [PA_W-1:0]   rsp_pa;
   logic              rsp_fault;
   logic [1:0]        rsp_fault_code;
   logic [VA_W-1:0]   rsp_fault_va;
   logic              walk_req_valid;
   logic [VPN_W-1:0]  walk_req_vpn;
   logic              walk_rsp_valid = 1'b0;
   logic              walk_rsp_present = 1'b0;
   logic [PFN_W-1:0]  walk_rsp_pfn = '0;
   logic              walk_rsp_writable = 1'b0;
   logic              walk_rsp_exec = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(12), .DEPTH(DEPTH)) u0 (.*);

   // bench page table
   function automatic logic pt_present(input logic [VPN_W-1:0] v);
      return v[3:0] != 4'hF;
   endfunction
   function automatic logic pt_w(input logic [VPN_W-1:0] v);
      return !v[4];
   endfunction
   function automatic logic pt_x(input logic [VPN_W-1:0] v);
      return v[5];
   endfunction
   function automatic logic [PFN_W-1:0] pt_pfn(input logic [VPN_W-1:0] v);
      return {4'h5, v ^ 36'h0_1234_5678};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [VA_W-1:0] va, input logic [1:0] t,
                         output logic f, output logic [1:0] c, output logic [PA_W-1:0] pa,
                         output logic [VA_W-1:0] fva, output int walks, output int lat,
                         output bit rdy_ok);
      bit done = 1'b0;
      f = 1'b0; c = 2'd3; pa = '0; fva = '0; walks = 0; lat = 0; rdy_ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_type = t;
      while (!done && lat < 60) begin
         #1;
         if (rsp_valid) begin
            f = rsp_fault; c = rsp_fault_code; pa = rsp_pa; fva = rsp_fault_va;
            done = 1'b1;
            req_valid = 1'b0;
         end else begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
            walk_rsp_valid = 1'b0;
            if (walk_req_valid) begin
               if (req_ready || walk_req_vpn != va[VA_W-1:12]) rdy_ok = 1'b0;
               walks++;
               walk_rsp_valid    = 1'b1;
               walk_rsp_present  = pt_present(walk_req_vpn);
               walk_rsp_pfn      = pt_pfn(walk_req_vpn);
               walk_rsp_writable = pt_w(walk_req_vpn);
               walk_rsp_exec     = pt_x(walk_req_vpn);
            end
         end
      end
      if (!done) chk(1'b0, "access timeout", 64'(lat), 64'd0);
      @(negedge clk);
      walk_rsp_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   function automatic logic [PA_W-1:0] exp_pa(input logic [VA_W-1:0] va);
      return {pt_pfn(va[VA_W-1:12]), va[11:0]};
   endfunction

   // pages: A writable+NX, B read-only+exec, C absent
   localparam logic [VPN_W-1:0] PG_A = 36'h100;
   localparam logic [VPN_W-1:0] PG_B = 36'h130;
   localparam logic [VPN_W-1:0] PG_C = 36'h20F;

   task automatic t_reset();
      #1;
      chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
      chk(walk_req_valid == 1'b0, "R1 walk", 64'(walk_req_valid), 64'd0);
      chk(rsp_valid == 1'b0, "R1 rsp", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_miss_hit();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r;
      access({PG_A, 12'h123}, 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 1, "R3 miss walks", 64'(w), 64'd1);
      chk(l == 2, "R3 miss latency", 64'(l), 64'd2);
      chk(r, "R3 stall and vpn", 64'(r), 64'd1);
      chk(pa == exp_pa({PG_A, 12'h123}) && !f, "R3 refill pa", 64'(pa), 64'(exp_pa({PG_A, 12'h123})));
      access({PG_A, 12'hABC}, 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 0 && l == 0, "R2 hit no walk", 64'(w * 100 + l), 64'd0);
      chk(pa == exp_pa({PG_A, 12'hABC}), "R2 hit pa", 64'(pa), 64'(exp_pa({PG_A, 12'hABC})));
      chk(!f && c == 2'd3, "R6 read clean", 64'({f, c}), 64'd3);
   endtask

   task automatic t_write_prot();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r;
      access({PG_B, 12'h010}, 2'd1, f, c, pa, fva, w, l, r);
      chk(f && c == 2'd1 && w == 1, "R4 write fault on refill", 64'({f, c}), 64'h5);
      chk(fva == {PG_B, 12'h010}, "R4 fault va", 64'(fva), 64'({PG_B, 12'h010}));
      access({PG_B, 12'h020}, 2'd1, f, c, pa, fva, w, l, r);
      chk(f && c == 2'd1 && w == 0 && l == 0, "R4 write fault on hit", 64'({f, c}), 64'h5);
      access({PG_B, 12'h030}, 2'd3, f, c, pa, fva, w, l, r);
      chk(!f && pa == exp_pa({PG_B, 12'h030}), "R6 kind 3 read", 64'(pa), 64'(exp_pa({PG_B, 12'h030})));
      access({PG_A, 12'h040}, 2'd1, f, c, pa, fva, w, l, r);
      chk(!f && c == 2'd3, "R6 write ok", 64'({f, c}), 64'd3);
   endtask

   task automatic t_exec_prot();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r;
      access({PG_A, 12'h500}, 2'd2, f, c, pa, fva, w, l, r);
      chk(f && c == 2'd2, "R5 exec fault", 64'({f, c}), 64'h6);
      chk(fva == {PG_A, 12'h500}, "R5 fault va", 64'(fva), 64'({PG_A, 12'h500}));
      access({PG_B, 12'h600}, 2'd2, f, c, pa, fva, w, l, r);
      chk(!f && pa == exp_pa({PG_B, 12'h600}), "R6 exec ok", 64'(pa), 64'(exp_pa({PG_B, 12'h600})));
   endtask

   task automatic t_absent();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r;
      access({PG_C, 12'h777}, 2'd0, f, c, pa, fva, w, l, r);
      chk(f && c == 2'd0 && l == 1, "R7 absent fault", 64'({f, c, 8'(l)}), 64'h401);
      chk(fva == {PG_C, 12'h777}, "R7 fault va", 64'(fva), 64'({PG_C, 12'h777}));
      access({PG_C, 12'h000}, 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 1 && f && c == 2'd0, "R7 not installed", 64'(w), 64'd1);
   endtask

   task automatic t_flush();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r;
      do_flush();
      access({PG_A, 12'h001}, 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 1, "R8 flush forces walk A", 64'(w), 64'd1);
      access({PG_B, 12'h001}, 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 1, "R8 flush forces walk B", 64'(w), 64'd1);
   endtask

   function automatic logic [VA_W-1:0] fill_va(input int i);
      return {36'h10000 + 36'(i << 8), 12'h0};
   endfunction

   task automatic t_replace();
      logic f; logic [1:0] c; logic [PA_W-1:0] pa; logic [VA_W-1:0] fva;
      int w; int l; bit r; int bad;
      do_flush();
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         access(fill_va(i), 2'd0, f, c, pa, fva, w, l, r);
         if (w != 1) bad++;
      end
      chk(bad == 0, "R9 fill walks", 64'(bad), 64'd0);
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         access(fill_va(i), 2'd0, f, c, pa, fva, w, l, r);
         if (w != 0 || pa != exp_pa(fill_va(i))) bad++;
      end
      chk(bad == 0, "R9 all resident", 64'(bad), 64'd0);
      access(fill_va(DEPTH), 2'd0, f, c, pa, fva, w, l, r);      // evicts entry 0
      chk(w == 1, "R9 new page walks", 64'(w), 64'd1);
      access(fill_va(2), 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 0, "R9 page 2 kept", 64'(w), 64'd0);
      access(fill_va(0), 2'd0, f, c, pa, fva, w, l, r);          // evicts entry 1
      chk(w == 1, "R9 page 0 evicted", 64'(w), 64'd1);
      access(fill_va(1), 2'd0, f, c, pa, fva, w, l, r);          // evicts entry 2
      chk(w == 1, "R9 page 1 evicted", 64'(w), 64'd1);
      access(fill_va(3), 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 0, "R9 page 3 kept", 64'(w), 64'd0);
      access(fill_va(2), 2'd0, f, c, pa, fva, w, l, r);
      chk(w == 1, "R9 page 2 evicted", 64'(w), 64'd1);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_miss_hit();
      t_write_prot();
      t_exec_prot();
      t_absent();
      t_flush();
      t_replace();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule